// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block holds the eight-bit status byte of one host-side USB transfer descriptor and revises it after every bus transaction run against that descriptor. Software arms the descriptor by writing a status byte with the Active bit set. That write also reloads a small error budget. After that, the transaction engine reports each outcome as a one-cycle strobe carrying an outcome code. The block folds the outcome into the status byte. It tracks sticky error flags, the ping and split protocol state, and the halt condition.

From the status byte and the endpoint configuration (speed, direction, periodic or asynchronous schedule), the block also selects which kind of token the engine should issue next. When a receive overrun occurs, it asserts a force-timeout signal in the same cycle so that the bus transaction is invalidated.

All pins are plain control and status signals. The outcome strobe has no back-pressure: the block accepts an outcome in any cycle. Each outcome takes effect on the next clock edge.

Top module: `td_status_updater`

## Requirements
- R1: While reset is low, the status byte is 0x00, halted is 0 and force_timeout is 0. Status bit positions: 7 Active, 6 Halted, 5 buffer error, 4 babble, 3 transaction error, 2 missed micro-frame, 1 split state, 0 ping state or split error.
- R2: A cycle with sw_wr_en high loads sw_wr_data into the status byte on the next edge and reloads the error budget to 3. A write takes priority over an outcome strobe in the same cycle.
- R3: A STALL outcome (code 2) sets Halted and clears Active in the same update. Any update that sets Halted also clears Active.
- R4: A babble outcome (code 3) sets bit 4 and also sets Halted and clears Active.
- R5: Timeout (4), CRC error (5) and bad PID (6) set bit 3, which stays set until the next software write. Each of these outcomes spends one unit of the error budget. The third one after arming sets Halted and clears Active.
- R6: Overrun (7) and underrun (8) set bit 5, which stays set until the next software write. An overrun strobe on an active descriptor drives force_timeout high in the same cycle as the strobe.
- R7: A missed complete-split outcome (11) sets bit 2 only when the endpoint is not high speed and is on the periodic schedule. Bit 2 is sticky.
- R8: For endpoints that are not high speed, an ACK (0) flips bit 1. next_tok is 2 (start-split) when bit 1 is 0 and 3 (complete-split) when bit 1 is 1.
- R9: For a high-speed OUT endpoint, NYET (10) sets bit 0 and ACK clears it. next_tok is 1 (PING) when bit 0 is 1 and 0 (plain token) otherwise. High-speed IN endpoints always get next_tok 0.
- R10: An ERR handshake (9) sets bit 0 only when the endpoint is not high speed and is periodic.
- R11: Outcome strobes have no effect while Active is 0. NAK (1), and outcomes outside the cases above, leave the byte unchanged.
- R12: Speed code 2'b10 means high speed. Any other value is treated as full or low speed. ep_dir_in is 1 for IN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write of the status byte (arms the descriptor) |
| sw_wr_data | input | 8 | Status byte to load |
| ep_speed | input | 2 | Endpoint speed code |
| ep_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| ep_periodic | input | 1 | Endpoint is on the periodic schedule |
| out_stb | input | 1 | One-cycle transaction outcome strobe |
| out_code | input | 4 | Outcome code |
| status | output | 8 | Current status byte |
| next_tok | output | 2 | Next token kind: 0 plain, 1 PING, 2 start-split, 3 complete-split |
| halted | output | 1 | Descriptor halted |
| force_timeout | output | 1 | Invalidate the current bus transaction |

## Verification
Any fault in the held state appears on the status port one edge after the strobe that exposes it. A wrong protocol bit also changes next_tok in that same cycle. A miscounted error budget stays hidden until the third error, when Halted either fails to rise or rises early. For that reason, the budget is exercised by sequences of errors and successes after each arm. Sweeping every outcome against every speed, direction and schedule setting, from each split and ping starting state, exposes conditional updates applied to the wrong kind of endpoint.

// File: rtl/td_status_pkg.sv
package td_status_pkg;
  localparam int STAT_W = 8;
  localparam int CODE_W = 4;
  localparam int N_CODES = 12;

  localparam int B_ACTIVE = 7;
  localparam int B_HALT   = 6;
  localparam int B_BUFERR = 5;
  localparam int B_BABBLE = 4;
  localparam int B_XERR   = 3;
  localparam int B_MISSED = 2;
  localparam int B_SPLIT  = 1;
  localparam int B_PING   = 0;

  typedef enum logic [CODE_W-1:0] {
    OC_ACK = 4'd0, OC_NAK = 4'd1, OC_STALL = 4'd2, OC_BABBLE = 4'd3,
    OC_TMO = 4'd4, OC_CRC = 4'd5, OC_BADPID = 4'd6, OC_OVR = 4'd7,
    OC_UNR = 4'd8, OC_ERRHS = 4'd9, OC_NYET = 4'd10, OC_MISSCS = 4'd11
  } outcome_e;

  typedef enum logic [1:0] {
    SPD_FULL = 2'b00, SPD_LOW = 2'b01, SPD_HIGH = 2'b10, SPD_RSVD = 2'b11
  } speed_e;

  typedef enum logic [1:0] {
    TK_PLAIN = 2'd0, TK_PING = 2'd1, TK_SSPLIT = 2'd2, TK_CSPLIT = 2'd3
  } token_e;

  typedef struct packed {
    logic ack;
    logic stall;
    logic babble;
    logic xerr;
    logic overrun;
    logic underrun;
    logic errhs;
    logic nyet;
    logic misscs;
  } evt_t;
endpackage

// File: rtl/td_outcome_decode.sv
module td_outcome_decode
  import td_status_pkg::*;
(
  input  logic              stb,
  input  logic              enable,
  input  logic [CODE_W-1:0] code,
  output evt_t              evt
);
  logic [N_CODES-1:0] hit;

  for (genvar i = 0; i < N_CODES; i++) begin : g_hit
    assign hit[i] = stb && enable && (code == CODE_W'(i));
  end

  always_comb begin
    evt          = '0;
    evt.ack      = hit[OC_ACK];
    evt.stall    = hit[OC_STALL];
    evt.babble   = hit[OC_BABBLE];
    evt.xerr     = hit[OC_TMO] | hit[OC_CRC] | hit[OC_BADPID];
    evt.overrun  = hit[OC_OVR];
    evt.underrun = hit[OC_UNR];
    evt.errhs    = hit[OC_ERRHS];
    evt.nyet     = hit[OC_NYET];
    evt.misscs   = hit[OC_MISSCS];
  end
endmodule

// File: rtl/td_err_budget.sv
module td_err_budget #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic spend,
  output logic exhausted
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (reload)                  cnt_q <= FULL;
    else if (spend && cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign exhausted = spend && !reload && (cnt_q <= ONE);
endmodule

// File: rtl/td_token_select.sv
module td_token_select
  import td_status_pkg::*;
(
  input  logic             high_speed,
  input  logic             dir_in,
  input  logic [STAT_W-1:0] stat,
  output logic [1:0]       tok
);
  always_comb begin
    if (!high_speed)
      tok = stat[B_SPLIT] ? TK_CSPLIT : TK_SSPLIT;
    else if (!dir_in && stat[B_PING])
      tok = TK_PING;
    else
      tok = TK_PLAIN;
  end
endmodule

// File: rtl/td_status_updater.sv
module td_status_updater
  import td_status_pkg::*;
#(
  parameter int ERR_CNT_W = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr_en,
  input  logic [7:0]  sw_wr_data,
  input  logic [1:0]  ep_speed,
  input  logic        ep_dir_in,
  input  logic        ep_periodic,
  input  logic        out_stb,
  input  logic [3:0]  out_code,
  output logic [7:0]  status,
  output logic [1:0]  next_tok,
  output logic        halted,
  output logic        force_timeout
);
  logic [STAT_W-1:0] stat_q, stat_d;
  evt_t              evt;
  logic              hs, split_ep, budget_out, take;

  assign hs       = (ep_speed == SPD_HIGH);
  assign split_ep = !hs;
  assign take     = !sw_wr_en;

  td_outcome_decode u_dec (
    .stb    (out_stb),
    .enable (stat_q[B_ACTIVE] && take),
    .code   (out_code),
    .evt    (evt)
  );

  td_err_budget #(.CNT_W(ERR_CNT_W)) u_budget (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload    (sw_wr_en),
    .spend     (evt.xerr),
    .exhausted (budget_out)
  );

  always_comb begin
    stat_d = stat_q;
    if (sw_wr_en) begin
      stat_d = sw_wr_data;
    end else begin
      if (evt.babble)                   stat_d[B_BABBLE] = 1'b1;
      if (evt.xerr)                     stat_d[B_XERR]   = 1'b1;
      if (evt.overrun || evt.underrun)  stat_d[B_BUFERR] = 1'b1;
      if (evt.misscs && split_ep && ep_periodic) stat_d[B_MISSED] = 1'b1;
      if (split_ep) begin
        if (evt.ack)                    stat_d[B_SPLIT] = ~stat_q[B_SPLIT];
        if (evt.errhs && ep_periodic)   stat_d[B_PING]  = 1'b1;
      end else if (!ep_dir_in) begin
        if (evt.nyet)                   stat_d[B_PING]  = 1'b1;
        if (evt.ack)                    stat_d[B_PING]  = 1'b0;
      end
      if (evt.stall || evt.babble || budget_out) begin
        stat_d[B_HALT]   = 1'b1;
        stat_d[B_ACTIVE] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  td_token_select u_tok (
    .high_speed (hs),
    .dir_in     (ep_dir_in),
    .stat       (stat_q),
    .tok        (next_tok)
  );

  assign status        = stat_q;
  assign halted        = stat_q[B_HALT];
  assign force_timeout = evt.overrun;
endmodule

// File: rtl/td_status_updater_chk.sv
module td_status_updater_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_wr_en,
  input logic [1:0] ep_speed,
  input logic       out_stb,
  input logic [7:0] status,
  input logic [1:0] next_tok,
  input logic       halted,
  input logic       force_timeout
);
  logic seen_clk;
  always_ff @(posedge clk) seen_clk <= rst_n;

  // R3
  halt_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_clk)
    ($rose(halted) && !$past(sw_wr_en)) |-> !status[7]);

  // R4
  babble_halts_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_clk)
    ($rose(status[4]) && !$past(sw_wr_en)) |-> halted);

  // R5
  xerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !sw_wr_en) |=> status[3]);

  // R6
  buferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !sw_wr_en) |=> status[5]);

  // R6
  force_tmo_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_timeout |-> (out_stb && status[7] && !sw_wr_en));

  // R11
  inactive_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[7] && !sw_wr_en) |=> $stable(status));

  // R8
  split_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_speed != 2'b10) |-> next_tok[1]);
endmodule

bind td_status_updater td_status_updater_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_wr_en      (sw_wr_en),
  .ep_speed      (ep_speed),
  .out_stb       (out_stb),
  .status        (status),
  .next_tok      (next_tok),
  .halted        (halted),
  .force_timeout (force_timeout)
);

// File: tb/td_status_updater_tb.sv
module td_status_updater_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_wr_en = 1'b0;
  logic [7:0] sw_wr_data = '0;
  logic [1:0] ep_speed = '0;
  logic       ep_dir_in = 1'b0;
  logic       ep_periodic = 1'b0;
  logic       out_stb = 1'b0;
  logic [3:0] out_code = '0;
  logic [7:0] status;
  logic [1:0] next_tok;
  logic       halted, force_timeout;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  td_status_updater dut_i (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(logic [7:0] s, logic [1:0] spd, logic din,
                                       logic per, int code);
    logic [7:0] r = s;
    logic hs = (spd == 2'b10);
    if (!s[7]) return s;
    case (code)
      2: r = (r | 8'h40) & 8'h7F;
      3: r = (r | 8'h50) & 8'h7F;
      4, 5, 6: r = r | 8'h08;
      7, 8: r = r | 8'h20;
      9: if (!hs && per) r = r | 8'h01;
      11: if (!hs && per) r = r | 8'h04;
      0: begin
        if (!hs) r = r ^ 8'h02;
        else if (!din) r = r & 8'hFE;
      end
      10: if (hs && !din) r = r | 8'h01;
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [1:0] tok_of(logic [7:0] s, logic [1:0] spd, logic din);
    if (spd != 2'b10) return s[1] ? 2'd3 : 2'd2;
    return (!din && s[0]) ? 2'd1 : 2'd0;
  endfunction

  task automatic arm(logic [7:0] v);
    @(negedge clk); sw_wr_en = 1'b1; sw_wr_data = v;
    @(negedge clk); sw_wr_en = 1'b0;
  endtask

  task automatic strobe(int code, output logic ft);
    out_stb = 1'b1; out_code = 4'(code);
    #1 ft = force_timeout;
    @(negedge clk); out_stb = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic ft;
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'h00);
    check("R1 halted", {7'd0, halted}, 8'h00);
    check("R1 force_timeout", {7'd0, force_timeout}, 8'h00);
    rst_n = 1'b1;

    // R2 R3..R12 sweep over speed, direction, schedule, start state, outcome
    for (int sp = 0; sp < 4; sp++)
      for (int d = 0; d < 2; d++)
        for (int p = 0; p < 2; p++)
          for (int st = 0; st < 4; st++)
            for (int c = 0; c < 12; c++) begin
              ep_speed = 2'(sp); ep_dir_in = d[0]; ep_periodic = p[0];
              arm(8'h80 | 8'(st));
              check("R2 armed", status, 8'h80 | 8'(st));
              strobe(c, ft);
              check("R6 force_timeout", {7'd0, ft}, {7'd0, (c == 7)});
              exp = model(8'h80 | 8'(st), 2'(sp), d[0], p[0], c);
              check("R3-R10 outcome update", status, exp);
              check("R8 R9 R12 next_tok", {6'd0, next_tok}, {6'd0, tok_of(exp, 2'(sp), d[0])});
              check("R3 halted pin", {7'd0, halted}, {7'd0, exp[6]});
            end

    // R5 error budget: two errors, ACKs, then third halts; rearm restores it
    ep_speed = 2'b10; ep_dir_in = 1'b1; ep_periodic = 1'b0;
    arm(8'h80);
    strobe(4, ft); strobe(0, ft); strobe(5, ft); strobe(0, ft);
    check("R5 two errors no halt", status, 8'h88);
    strobe(6, ft);
    check("R5 third error halts", status, 8'h48);
    arm(8'h80);
    strobe(4, ft); strobe(4, ft);
    check("R5 budget reloaded", status, 8'h88);
    strobe(4, ft);
    check("R5 halt after reload", status, 8'h48);

    // R11 inactive: strobes ignored, force_timeout quiet
    for (int c = 0; c < 16; c++) begin
      strobe(c, ft);
      check("R11 inactive ignored", status, 8'h48);
      check("R11 no force_timeout", {7'd0, ft}, 8'h00);
    end

    // R6 sticky buffer error, R7 sticky missed bit across successes
    ep_speed = 2'b00; ep_periodic = 1'b1;
    arm(8'h80);
    strobe(8, ft); strobe(11, ft); strobe(0, ft); strobe(0, ft); strobe(1, ft);
    check("R6 R7 sticky", status, 8'hA4);

    // R9 ping sequence on high-speed OUT
    ep_speed = 2'b10; ep_dir_in = 1'b0;
    arm(8'h80);
    strobe(10, ft);
    check("R9 NYET -> PING", {6'd0, next_tok}, 8'd1);
    strobe(1, ft);
    check("R9 NAK holds ping", status, 8'h81);
    strobe(0, ft);
    check("R9 ACK -> OUT", {6'd0, next_tok}, 8'd0);

    // R2 write wins over a simultaneous strobe
    @(negedge clk); sw_wr_en = 1'b1; sw_wr_data = 8'h80; out_stb = 1'b1; out_code = 4'd2;
    @(negedge clk); sw_wr_en = 1'b0; out_stb = 1'b0;
    #1 check("R2 write priority", status, 8'h80);

    finish_run();
  end
endmodule